// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge and Level Sources

This block gathers up to 32 interrupt request lines and drives a single interrupt line to a processor. Each source is fixed at build time, through a parameter mask, as either edge-triggered (rising edge) or level-sensitive. Captured requests are held in a status register and qualified by an enable register. The qualified set is the pending view. A priority encoder picks the lowest-numbered pending source and reports its index through a vector register. Software reads that index, services the source and clears it by writing ones to an acknowledge location.

The enable register can be loaded as a whole. It also has two write-one aliases, one that sets bits and one that clears bits, so no read-modify-write is needed. A two-bit master register must have both bits set before the output line can assert. Only the lowest `NumSrc` sources are live.

Access is through a simple 32-bit port with a word index, a write strobe and a combinational read path.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The word index `busAddr` selects the registers as follows: 0 status (read-only), 1 pending (read-only), 2 enable (read/write), 3 acknowledge (write-only), 4 set-enable alias (write-only), 5 clear-enable alias (write-only), 6 vector (read-only) and 7 master (read/write, bits [1:0]). A write happens at a rising clock edge when `busSel` and `busWe` are both high. Read data follows `busAddr` combinationally.
- R2: After reset, status, enable and master read as zero, vector reads 0xFFFFFFFF and `irqOut` is low.
- R3: An edge source (its `EdgeMask` bit is 1) sets its status bit at the first clock edge that sees the input high after it was low. The bit stays set after the input falls. Once acknowledged, it stays clear while the input remains high, until a new rising edge arrives.
- R4: A level source (its `EdgeMask` bit is 0) sets its status bit at every clock edge where the input is high. If the input is still high when the bit is acknowledged, the bit reads clear for one cycle and is set again at the following edge.
- R5: A write to the acknowledge index clears every status bit where the written word has a one and leaves the other bits unchanged. Writing 0xFFFFFFFF clears all status bits.
- R6: A write to the enable index loads the word, and writing zero there is legal. The set-enable alias ORs the written ones into enable. The clear-enable alias clears the enable bits where the written word has ones.
- R7: Pending reads as status AND enable.
- R8: Vector reads the index of the lowest-numbered pending source, which has the highest priority. It reads 0xFFFFFFFF when nothing is pending.
- R9: `irqOut` is high exactly when pending is nonzero and master bits 0 and 1 are both set. It follows register updates within the same cycle.
- R10: Sources at index `NumSrc` and above never set status, and their enable bits always read zero.
- R11: Writes to the status, pending and vector indices have no effect. Reads of the acknowledge, set-enable and clear-enable indices return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 32 | Interrupt request lines, one per source |
| busSel | input | 1 | Access select |
| busWe | input | 1 | Write strobe, qualified by busSel |
| busAddr | input | 3 | Word index of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irqOut | output | 1 | Interrupt line to the processor |

## Verification
Every register write and every input capture takes effect at the first rising edge after it is driven. Reads and `irqOut` are combinational from registers, so each result is due one edge after its stimulus. The bench drives on the falling edge and samples at the next falling edge, half a period after the edge that updates the state.

The acknowledge of a level source that is still high is the one case that spans two edges. The bench samples it twice: right after the acknowledge edge it expects the bit clear, and one edge later it expects the bit set again. Edge sources are checked over several idle cycles after an acknowledge to show that no re-capture happens.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int DataW = 32;
  localparam int AddrW = 3;

  // word indices of the register map
  typedef enum logic [AddrW-1:0] {
    RegStatus  = 3'd0,
    RegPending = 3'd1,
    RegEnable  = 3'd2,
    RegAck     = 3'd3,
    RegSetEn   = 3'd4,
    RegClrEn   = 3'd5,
    RegVector  = 3'd6,
    RegMaster  = 3'd7
  } irqvReg_e;

  // write strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic setEn;
    logic clrEn;
    logic ack;
    logic loadMaster;
  } irqvStrobe_t;

endpackage

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int Width = 32,
  localparam int OutW = 32
) (
  input  logic [Width-1:0] req,
  output logic [OutW-1:0]  vector
);

  // scan from the top down so the lowest index is the last to win
  always_comb begin
    vector = {OutW{1'b1}};
    for (int i = Width - 1; i >= 0; i--) begin
      if (req[i]) vector = OutW'(i);
    end
  end

endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
(
  input  logic             busSel,
  input  logic             busWe,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] statusQ,
  input  logic [DataW-1:0] pendingQ,
  input  logic [DataW-1:0] enableQ,
  input  logic [DataW-1:0] vectorQ,
  input  logic [1:0]       masterQ,
  output irqvStrobe_t      stb,
  output logic [DataW-1:0] busRdata
);

  logic wrEn;
  irqvReg_e regSel;

  assign wrEn   = busSel & busWe;
  assign regSel = irqvReg_e'(busAddr);

  always_comb begin
    stb            = '0;
    stb.loadEn     = wrEn && (regSel == RegEnable);
    stb.setEn      = wrEn && (regSel == RegSetEn);
    stb.clrEn      = wrEn && (regSel == RegClrEn);
    stb.ack        = wrEn && (regSel == RegAck);
    stb.loadMaster = wrEn && (regSel == RegMaster);
  end

  always_comb begin
    unique case (regSel)
      RegStatus:  busRdata = statusQ;
      RegPending: busRdata = pendingQ;
      RegEnable:  busRdata = enableQ;
      RegVector:  busRdata = vectorQ;
      RegMaster:  busRdata = {{(DataW-2){1'b0}}, masterQ};
      default:    busRdata = '0;
    endcase
  end

  // R1
  always_comb begin
    strobe_onehot_chk: assert ($onehot0(stb));
  end

endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int NumSrc = 8,
  parameter logic [DataW-1:0] EdgeMask = 32'h0000_000F,
  localparam int IdxW = $clog2(DataW),
  localparam logic [DataW-1:0] ValidMask =
    (NumSrc >= DataW) ? {DataW{1'b1}} : DataW'((64'd1 << NumSrc) - 64'd1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DataW-1:0] irqIn,
  input  irqvStrobe_t      stb,
  input  logic [DataW-1:0] wdata,
  output logic [DataW-1:0] statusQ,
  output logic [DataW-1:0] pendingQ,
  output logic [DataW-1:0] enableQ,
  output logic [DataW-1:0] vectorQ,
  output logic [1:0]       masterQ,
  output logic             irqOut
);

  logic [DataW-1:0] prevIn;
  logic [DataW-1:0] riseIn;
  logic [DataW-1:0] setReq;
  logic [DataW-1:0] ackMask;
  logic [DataW-1:0] statusD;
  logic [DataW-1:0] enableD;

  assign riseIn  = irqIn & ~prevIn;
  assign setReq  = ((riseIn & EdgeMask) | (irqIn & ~EdgeMask)) & ValidMask;
  assign ackMask = stb.ack ? wdata : '0;
  // acknowledge wins over a capture in the same cycle
  assign statusD = (statusQ | setReq) & ~ackMask;

  always_comb begin
    enableD = enableQ;
    if (stb.loadEn)     enableD = wdata & ValidMask;
    else if (stb.setEn) enableD = enableQ | (wdata & ValidMask);
    else if (stb.clrEn) enableD = enableQ & ~wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn  <= '0;
      statusQ <= '0;
      enableQ <= '0;
      masterQ <= '0;
    end else begin
      prevIn  <= irqIn;
      statusQ <= statusD;
      enableQ <= enableD;
      if (stb.loadMaster) masterQ <= wdata[1:0];
    end
  end

  assign pendingQ = statusQ & enableQ;
  assign irqOut   = (&masterQ) & (|pendingQ);

  irqv_prio #(.Width(DataW)) uPrio (
    .req    (pendingQ),
    .vector (vectorQ)
  );

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> ((statusQ & $past(wdata)) == '0));

  // R6
  set_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setEn |=> ((enableQ & $past(wdata & ValidMask)) == $past(wdata & ValidMask)));

  // R6
  clear_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrEn |=> ((enableQ & $past(wdata)) == '0));

  // R3
  edge_needs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((statusQ & ~$past(statusQ)) & EdgeMask) & ~$past(irqIn & ~prevIn)) == '0);

  // R10
  inert_sources_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ | enableQ) & ~ValidMask) == '0);

  // R8
  vector_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vectorQ != {DataW{1'b1}}) |->
      (pendingQ[vectorQ[IdxW-1:0]] &&
       ((pendingQ & ((DataW'(1) << vectorQ[IdxW-1:0]) - DataW'(1))) == '0)));

  // R8
  vector_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ == '0) |-> (vectorQ == {DataW{1'b1}}));

  // R9
  master_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadMaster && (wdata[1:0] != 2'b11)) |=> !irqOut);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NumSrc = 8,
  parameter logic [31:0] EdgeMask = 32'h0000_000F
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] irqIn,
  input  logic        busSel,
  input  logic        busWe,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irqOut
);

  irqvStrobe_t      stb;
  logic [DataW-1:0] statusQ;
  logic [DataW-1:0] pendingQ;
  logic [DataW-1:0] enableQ;
  logic [DataW-1:0] vectorQ;
  logic [1:0]       masterQ;

  irqv_ctrl uCtrl (
    .busSel   (busSel),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .statusQ  (statusQ),
    .pendingQ (pendingQ),
    .enableQ  (enableQ),
    .vectorQ  (vectorQ),
    .masterQ  (masterQ),
    .stb      (stb),
    .busRdata (busRdata)
  );

  irqv_datapath #(.NumSrc(NumSrc), .EdgeMask(EdgeMask)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .stb      (stb),
    .wdata    (busWdata),
    .statusQ  (statusQ),
    .pendingQ (pendingQ),
    .enableQ  (enableQ),
    .vectorQ  (vectorQ),
    .masterQ  (masterQ),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  localparam logic [31:0] None = 32'hFFFF_FFFF;

  always #10 clk = ~clk;

  irq_vector_ctrl #(.NumSrc(8), .EdgeMask(32'h0000_000F)) u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk);
    irqIn = irqIn | m;
    @(negedge clk);
    irqIn = irqIn & ~m;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(3'd0, v); chk("R2 status", v, 0);
    rd(3'd2, v); chk("R2 enable", v, 0);
    rd(3'd7, v); chk("R2 master", v, 0);
    rd(3'd6, v); chk("R2 vector", v, None);
    chk("R2 irqOut", 32'(irqOut), 0);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    wr(3'd2, 32'h05); rd(3'd2, v); chk("R6 load", v, 32'h05);
    wr(3'd4, 32'h0A); rd(3'd2, v); chk("R6 set alias", v, 32'h0F);
    wr(3'd5, 32'h03); rd(3'd2, v); chk("R6 clear alias", v, 32'h0C);
    wr(3'd2, 32'h00); rd(3'd2, v); chk("R6 load zero", v, 32'h00);
    wr(3'd2, None);   rd(3'd2, v); chk("R10 enable upper bits", v, 32'hFF);
    wr(3'd4, 32'hFFFF_0000); rd(3'd2, v); chk("R10 set alias upper", v, 32'hFF);
    rd(3'd3, v); chk("R11 read ack index", v, 0);
    rd(3'd4, v); chk("R11 read set index", v, 0);
    rd(3'd5, v); chk("R1 R11 read clear index", v, 0);
  endtask

  task automatic testEdge();
    logic [31:0] v;
    wr(3'd7, 32'h3);
    pulse(32'h04);
    rd(3'd0, v); chk("R3 edge pulse latched", v, 32'h04);
    rd(3'd1, v); chk("R7 pending", v, 32'h04);
    rd(3'd6, v); chk("R8 vector edge", v, 32'd2);
    chk("R9 irqOut high", 32'(irqOut), 1);
    wr(3'd3, 32'h04);
    rd(3'd0, v); chk("R3 ack clears", v, 0);
    chk("R9 irqOut low after ack", 32'(irqOut), 0);
    @(negedge clk); irqIn[1] = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R3 held edge latched", v, 32'h02);
    wr(3'd3, 32'h02);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R3 no recapture while high", v, 0);
    irqIn[1] = 1'b0;
    @(negedge clk); irqIn[1] = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R3 new rise recaptures", v, 32'h02);
    irqIn[1] = 1'b0;
    wr(3'd3, None);
  endtask

  task automatic testLevel();
    logic [31:0] v;
    @(negedge clk); irqIn[5] = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R4 level latched", v, 32'h20);
    wr(3'd3, 32'h20);
    rd(3'd0, v); chk("R4 clear right after ack", v, 0);
    @(negedge clk);
    rd(3'd0, v); chk("R4 resets while high", v, 32'h20);
    irqIn[5] = 1'b0;
    wr(3'd3, 32'h20);
    @(negedge clk);
    rd(3'd0, v); chk("R4 stays clear when low", v, 0);
  endtask

  task automatic testAck();
    logic [31:0] v;
    pulse(32'h11);
    rd(3'd0, v); chk("R5 two captured", v, 32'h11);
    wr(3'd3, 32'h01);
    rd(3'd0, v); chk("R5 partial ack", v, 32'h10);
    pulse(32'h08);
    rd(3'd0, v); chk("R5 more captured", v, 32'h18);
    wr(3'd3, None);
    rd(3'd0, v); chk("R5 ack all", v, 0);
  endtask

  task automatic testPriority();
    logic [31:0] v;
    pulse(32'hC2);
    wr(3'd2, 32'hC0);
    rd(3'd1, v); chk("R7 pending masked", v, 32'hC0);
    rd(3'd6, v); chk("R8 vector among enabled", v, 32'd6);
    wr(3'd2, 32'hFF);
    rd(3'd6, v); chk("R8 lowest wins", v, 32'd1);
    wr(3'd5, 32'hFF);
    rd(3'd6, v); chk("R8 none enabled", v, None);
    rd(3'd0, v); chk("R7 status kept", v, 32'hC2);
    chk("R9 irqOut low none pending", 32'(irqOut), 0);
    wr(3'd3, None);
  endtask

  task automatic testMaster();
    logic [31:0] v;
    pulse(32'h01);
    wr(3'd2, 32'h01);
    wr(3'd7, 32'h1); chk("R9 only bit0", 32'(irqOut), 0);
    wr(3'd7, 32'h2); chk("R9 only bit1", 32'(irqOut), 0);
    wr(3'd7, 32'h3); chk("R9 both bits", 32'(irqOut), 1);
    rd(3'd7, v); chk("R1 master readback", v, 32'h3);
    wr(3'd0, None);
    wr(3'd1, 32'h0);
    wr(3'd6, 32'h0);
    rd(3'd0, v); chk("R11 status write ignored", v, 32'h01);
    rd(3'd6, v); chk("R11 vector write ignored", v, 32'd0);
    wr(3'd3, None);
    chk("R9 low after ack", 32'(irqOut), 0);
  endtask

  task automatic testInert();
    logic [31:0] v;
    wr(3'd2, None);
    @(negedge clk); irqIn = 32'hFFFF_FF00;
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R10 upper sources inert", v, 0);
    chk("R10 irqOut low", 32'(irqOut), 0);
    irqIn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testEdge();
    testLevel();
    testAck();
    testPriority();
    testMaster();
    testInert();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule